// File: doc/BRIEF.md
# Wrapping Counter Width Extender

This block widens a free-running counter that wraps. A sampler reads the low counter from time to time and presents each reading with a strobe. The block compares each reading with the one before it. When the new reading is strictly smaller than the stored one, the low counter has wrapped, and a high word is incremented. The block then returns the wide time value: the high word above the current reading.

This scheme works only if readings arrive more often than the low counter wraps. If a whole wrap period passes between two readings, that wrap is lost. A ready input tells the block whether the counter source is up. While ready is low, the reading is taken as zero.

The first reading after reset has nothing to compare against, so it never counts as a wrap. Both widths are parameters. The output width is their sum.

Top module: `wrap_ext64`

## Requirements
- R1: While `rst` is high (synchronous, active high), `out_vld` is 0 and `out_val` is 0. After reset is released, the high word starts from 0.
- R2: `out_vld` is high in exactly the cycle after each cycle in which `smp_vld` is high, and it is low at every other time.
- R3: When `out_vld` is high, bits [LOW_W-1:0] of `out_val` equal the effective sample taken one cycle earlier.
- R4: A strobed sample that is strictly less than the stored previous sample counts as a wrap. The high word in bits [OUT_W-1:LOW_W] of `out_val` is then one greater than it was for the previous sample.
- R5: A strobed sample that is equal to or greater than the stored previous sample leaves the high word unchanged.
- R6: The first strobed sample after reset never counts as a wrap, whatever was sampled before the reset.
- R7: While `src_rdy` is 0, the effective sample is zero whatever `smp_val` holds. A zero sample that follows a non-zero stored sample counts as a wrap.
- R8: The high word wraps silently from its all-ones value to 0.
- R9: In cycles with no strobe, `out_val` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strobe: a sample of the low counter is present |
| smp_val | input | LOW_W | Sampled low counter value |
| src_rdy | input | 1 | Counter source ready; when 0 the sample is taken as zero |
| out_vld | output | 1 | One-cycle pulse: `out_val` has just been updated |
| out_val | output | LOW_W+HIGH_W | Extended value {high word, sample} |

## Verification
The case hardest to reach from the ports is the rollover of the high word. With a 32-bit high word, the rollover needs 2^32 detected wraps. The bench therefore adds a second instance with a 4-bit high word and an 8-bit low word. It alternates high and low samples on that instance until the sixteenth wrap brings the high word back to zero. A second hard case is the discarding of the stored sample at reset. The bench loads a large sample, resets the block, and then checks that a small first sample does not count as a wrap.

// File: rtl/wx_pkg.sv
package wx_pkg;
  localparam int unsigned WX_DEF_LOW_W  = 32;
  localparam int unsigned WX_DEF_HIGH_W = 32;
endpackage

// File: rtl/wx_wrap_det.sv
module wx_wrap_det #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [W-1:0] smp,
  output logic         wrap
);
  logic [W-1:0] prev_q;
  logic         prev_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (vld) begin
      prev_q    <= smp;
      prev_ok_q <= 1'b1;
    end
  end

  // Count a wrap only when a stored sample exists and the new one is strictly smaller.
  assign wrap = vld && prev_ok_q && (prev_q > smp);

  assert_no_stale_prev_R6: assert property (@(posedge clk) rst |=> !prev_ok_q)
    else $error("stored sample survived reset");
  assert_prev_stored_R4: assert property (@(posedge clk) disable iff (rst)
    vld |=> (prev_ok_q && prev_q == $past(smp)))
    else $error("sample not stored");
  assert_first_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !prev_ok_q |-> !wrap)
    else $error("wrap counted with no stored sample");
endmodule

// File: rtl/wx_high_cnt.sv
module wx_high_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] high_q,
  output logic [W-1:0] high_nx
);
  localparam logic [W-1:0] ONE = W'(1);

  assign high_nx = inc ? high_q + ONE : high_q;

  always_ff @(posedge clk) begin
    if (rst) high_q <= '0;
    else     high_q <= high_nx;
  end

  assert_high_reset_R1: assert property (@(posedge clk) rst |=> high_q == '0)
    else $error("high word not cleared");
  assert_high_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(high_q))
    else $error("high word moved without wrap");
  assert_high_roll_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && high_q == '1) |=> high_q == '0)
    else $error("high word did not roll over");
endmodule

// File: rtl/wx_compose.sv
module wx_compose #(
  parameter int unsigned LW = 32,
  parameter int unsigned HW = 32,
  localparam int unsigned OW = LW + HW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic [HW-1:0] hi,
  input  logic [LW-1:0] lo,
  output logic          out_vld,
  output logic [OW-1:0] out_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_val <= '0;
    end else begin
      out_vld <= vld;
      if (vld) out_val <= {hi, lo};
    end
  end

  assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    vld |=> out_vld)
    else $error("missing output strobe");
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !vld |=> (!out_vld && $stable(out_val)))
    else $error("output changed without strobe");
endmodule

// File: rtl/wrap_ext64.sv
module wrap_ext64 #(
  parameter int unsigned LOW_W  = wx_pkg::WX_DEF_LOW_W,
  parameter int unsigned HIGH_W = wx_pkg::WX_DEF_HIGH_W,
  localparam int unsigned OUT_W = LOW_W + HIGH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [LOW_W-1:0] smp_val,
  input  logic             src_rdy,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_val
);
  logic [LOW_W-1:0]  eff_smp;
  logic              wrap;
  logic [HIGH_W-1:0] high_q;
  logic [HIGH_W-1:0] high_nx;

  // Source not ready: the reading is zero.
  assign eff_smp = src_rdy ? smp_val : '0;

  wx_wrap_det #(.W(LOW_W)) u_det (
    .clk(clk), .rst(rst), .vld(smp_vld), .smp(eff_smp), .wrap(wrap)
  );

  wx_high_cnt #(.W(HIGH_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(wrap), .high_q(high_q), .high_nx(high_nx)
  );

  wx_compose #(.LW(LOW_W), .HW(HIGH_W)) u_out (
    .clk(clk), .rst(rst), .vld(smp_vld), .hi(high_nx), .lo(eff_smp),
    .out_vld(out_vld), .out_val(out_val)
  );

  assert_out_reset_R1: assert property (@(posedge clk) rst |=> (!out_vld && out_val == '0))
    else $error("outputs not cleared");
  assert_low_half_R3: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> out_val[LOW_W-1:0] == $past(eff_smp))
    else $error("low half mismatch");
  assert_not_ready_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !src_rdy) |=> out_val[LOW_W-1:0] == '0)
    else $error("unready sample not zero");
  assert_out_high_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> out_val[OUT_W-1:LOW_W] == high_q)
    else $error("high half differs from counter");
endmodule

// File: tb/wrap_ext64_bench.sv
module wrap_ext64_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        smp_vld = 1'b0;
  logic [31:0] smp_val = '0;
  logic        src_rdy = 1'b1;
  logic        out_vld;
  logic [63:0] out_val;

  logic        s_vld = 1'b0;
  logic [7:0]  s_val = '0;
  logic        s_out_vld;
  logic [11:0] s_out_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  wrap_ext64 u_wrap_ext64 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_val(smp_val), .src_rdy(src_rdy),
    .out_vld(out_vld), .out_val(out_val)
  );

  wrap_ext64 #(.LOW_W(8), .HIGH_W(4)) u_small (
    .clk(clk), .rst(rst), .smp_vld(s_vld), .smp_val(s_val), .src_rdy(1'b1),
    .out_vld(s_out_vld), .out_val(s_out_val)
  );

  // Fields: {ready, sample, expected high word}
  localparam int NV = 10;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 32'd100,        32'd0},  // R6 first sample
    {1'b1, 32'd100,        32'd0},  // R5 equal
    {1'b1, 32'd5000,       32'd0},  // R5 greater
    {1'b1, 32'hFFFF_FFF0,  32'd0},
    {1'b1, 32'd3,          32'd1},  // R4 wrap
    {1'b1, 32'd3,          32'd1},
    {1'b0, 32'h0000_DEAD,  32'd2},  // R7 zero sample wraps
    {1'b1, 32'd0,          32'd2},
    {1'b1, 32'd7,          32'd2},
    {1'b1, 32'd6,          32'd3}   // R4 off by one
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic rdy, input logic [31:0] v);
    smp_vld = 1'b1; smp_val = v; src_rdy = rdy;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic s_strobe(input logic [7:0] v);
    s_vld = 1'b1; s_val = v;
    @(negedge clk);
    s_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_vld in reset", {63'd0, out_vld}, 64'd0);
    chk("R1 out_val in reset", out_val, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 no strobe no valid", {63'd0, out_vld}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] lo;
      lo = VEC[i][64] ? VEC[i][63:32] : 32'd0;
      strobe(VEC[i][64], VEC[i][63:32]);
      chk($sformatf("R2 valid vec%0d", i), {63'd0, out_vld}, 64'd1);
      chk($sformatf("R3/R4 value vec%0d", i), out_val, {VEC[i][31:0], lo});
    end
    src_rdy = 1'b1;

    // R9 / R2: idle cycles hold the value and keep valid low
    @(negedge clk);
    chk("R2 valid drops", {63'd0, out_vld}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R9 hold", out_val, {32'd3, 32'd6});

    // R6: a large sample before reset must not cause a wrap after it
    strobe(1'b1, 32'hFFFF_0000);
    chk("R6 pre-reset value", out_val, {32'd3, 32'hFFFF_0000});
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset clears", out_val, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    strobe(1'b1, 32'd10);
    chk("R6 first after reset", out_val, {32'd0, 32'd10});

    // R8: high word rollover on the narrow instance
    s_strobe(8'd200);
    for (int k = 1; k <= 16; k++) begin
      s_strobe(8'd100);
      if (k == 15) chk("R8 high at max", {52'd0, s_out_val}, {52'd0, 4'hF, 8'd100});
      if (k == 16) chk("R8 high rolls to zero", {52'd0, s_out_val}, {52'd0, 4'h0, 8'd100});
      s_strobe(8'd200);
    end
    chk("R5 narrow no wrap on rise", {52'd0, s_out_val}, {52'd0, 4'h0, 8'd200});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule